// File: doc/BRIEF.md
# Sprite Line Buffer with Clear-on-Read Replay

This block holds one scan line's worth of sprite pixels. While the beam is in the horizontal blanking interval, a fetch engine presents one 8-pixel strip per clock, and each strip is drawn into the buffer starting at a given X position. A sprite 16 pixels wide arrives as two strips on consecutive fetches, the second placed 8 pixels to the right of the first.

In the second half of each line the buffer is replayed in pixel order, one entry per clock. Each entry is erased in the same cycle it is read, so the buffer is empty again when the next blanking interval begins. No separate clear pass is needed.

A registered output stage passes the replayed pixel on to the colour lookup and raises a valid flag. During vertical blanking this stage is held off. Drawing, replay and erasing still run exactly as they do on a visible line.

Top module: `sprLineBuf`

## Requirements
- R1: While reset is low, both outputs are 0 and every buffer entry is set to 0. A strip drawn before a reset reads back as 0 on the replay after that reset.
- R2: A strip is written only when `stripEn` is 1 and `hCount` lies in 144..239, both ends included. A strip presented at any other H value, or with `stripEn` at 0, changes no entry.
- R3: Pixel i of a strip is taken from `stripPix[4*i+3:4*i]`, for i from 0 to 7. It is written to entry `stripX + i`.
- R4: Strip entry addresses wrap modulo 256. A strip at X = 252 fills entries 252..255 and then 0..3.
- R5: A pixel value of 0 is transparent and leaves the entry unchanged. A non-zero pixel replaces whatever the entry held, so a later strip wins wherever it is opaque.
- R6: For `hCount` in 256..511, entry `hCount - 256` is read. Its value appears on `pixColour` one clock later, with `pixValid` at 1. At every other H, `pixValid` is 0 and `pixColour` is 0 one clock later.
- R7: Every entry is cleared to 0 in the cycle it is read. A line with no strips drawn therefore replays all zeros after any earlier line.
- R8: With `vBlank` at 1 during replay, `pixValid` and `pixColour` stay 0. Drawing and the clear-on-read still take place, so nothing drawn on a blanked line survives to the next line.
- R9: Two strips at X and X+8, presented on consecutive fetch slots, replay as 16 contiguous pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hCount | input | 9 | Horizontal position. Counts 128..511 and then wraps back to 128 |
| vBlank | input | 1 | High during vertical blanking. Gates the output stage |
| stripEn | input | 1 | A strip is presented this cycle |
| stripX | input | 8 | Entry that receives pixel 0 of the strip |
| stripPix | input | 32 | Eight 4-bit pixels. Pixel i is at bits 4i+3..4i |
| pixColour | output | 4 | Replayed pixel, sent to the colour lookup |
| pixValid | output | 1 | `pixColour` carries a visible replayed pixel |

## Verification
The assertions assume that `hCount` advances by exactly one per clock and wraps from 511 to 128. They assume this also while reset is being applied, because the read-address sequencing and the clear-after-read checks rest on that stepping. The bench owns a single H counter, which it advances once per clock inside its one drive task, and it never pauses or jumps that counter, not even across the mid-line reset. Strips are only presented at scheduled H values, and these include slots outside the drawing window, so the window checks see stimulus that is legal but ignored.

// File: rtl/sprLineBuf_pkg.sv
package sprLineBuf_pkg;

  // Strobes handed from the timing control to the buffer datapath.
  typedef struct packed {
    logic wrEn;    // draw the presented strip this cycle
    logic rdEn;    // replay and erase the addressed entry
    logic showEn;  // replayed pixel is visible
  } lbCtrl_t;

endpackage

// File: rtl/sprLbCtrl.sv
module sprLbCtrl
  import sprLineBuf_pkg::*;
#(
  parameter int HCNT_W     = 9,
  parameter int ADDR_W     = 8,
  parameter int H_FIRST    = 128,
  parameter int H_LAST     = 511,
  parameter int DRAW_FIRST = 144,
  parameter int DRAW_LAST  = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] hCount,
  input  logic              vBlank,
  input  logic              stripEn,
  output lbCtrl_t           ctrl,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int READ_FIRST = H_LAST + 1 - DEPTH;

  logic inDraw;
  logic inRead;

  assign inDraw = (hCount >= HCNT_W'(DRAW_FIRST)) && (hCount <= HCNT_W'(DRAW_LAST));
  assign inRead = (hCount >= HCNT_W'(READ_FIRST)) && (hCount <= HCNT_W'(H_LAST));

  always_comb begin
    ctrl.wrEn   = stripEn && inDraw;
    ctrl.rdEn   = inRead;
    ctrl.showEn = inRead && !vBlank;
  end

  assign rdAddr = ADDR_W'(hCount - HCNT_W'(READ_FIRST));

  // R6 (input assumption: H steps by one and wraps to its first value)
  hcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hCount == (($past(hCount) == HCNT_W'(H_LAST)) ? HCNT_W'(H_FIRST)
                                                  : HCNT_W'($past(hCount) + 1'b1)));

  // R6
  rdaddr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.rdEn && rdAddr != ADDR_W'(DEPTH - 1)) |=>
      (ctrl.rdEn && rdAddr == ADDR_W'($past(rdAddr) + 1'b1)));

endmodule

// File: rtl/sprLbData.sv
module sprLbData
  import sprLineBuf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PIX_W     = 4,
  parameter int STRIP_LEN = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  lbCtrl_t                     ctrl,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [ADDR_W-1:0]           stripX,
  input  logic [STRIP_LEN*PIX_W-1:0]  stripPix,
  output logic [PIX_W-1:0]            pixColour,
  output logic                        pixValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [PIX_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] laneAddr [STRIP_LEN];
  logic [PIX_W-1:0]  lanePix  [STRIP_LEN];
  logic              laneHit  [STRIP_LEN];

  // One write lane per strip pixel; the address wraps with the entry width.
  for (genvar l = 0; l < STRIP_LEN; l++) begin : g_lane
    assign laneAddr[l] = stripX + ADDR_W'(l);
    assign lanePix[l]  = stripPix[l*PIX_W +: PIX_W];
    assign laneHit[l]  = ctrl.wrEn && (lanePix[l] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      if (ctrl.rdEn) mem[rdAddr] <= '0;
      for (int l = 0; l < STRIP_LEN; l++) begin
        if (laneHit[l]) mem[laneAddr[l]] <= lanePix[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixValid  <= 1'b0;
      pixColour <= '0;
    end else begin
      pixValid  <= ctrl.showEn;
      pixColour <= ctrl.showEn ? mem[rdAddr] : '0;
    end
  end

  // R2 (draw and replay windows never overlap)
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.wrEn |-> !ctrl.rdEn);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rdEn |=> (mem[$past(rdAddr)] == '0));

  // R3
  strip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    laneHit[0] |=> (mem[$past(laneAddr[0])] == $past(lanePix[0])));

endmodule

// File: rtl/sprLineBuf.sv
module sprLineBuf
  import sprLineBuf_pkg::*;
#(
  parameter int HCNT_W     = 9,
  parameter int ADDR_W     = 8,
  parameter int PIX_W      = 4,
  parameter int STRIP_LEN  = 8,
  parameter int H_FIRST    = 128,
  parameter int H_LAST     = 511,
  parameter int DRAW_FIRST = 144,
  parameter int DRAW_LAST  = 239
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [HCNT_W-1:0]           hCount,
  input  logic                        vBlank,
  input  logic                        stripEn,
  input  logic [ADDR_W-1:0]           stripX,
  input  logic [STRIP_LEN*PIX_W-1:0]  stripPix,
  output logic [PIX_W-1:0]            pixColour,
  output logic                        pixValid
);

  localparam int READ_FIRST = H_LAST + 1 - (1 << ADDR_W);

  lbCtrl_t           ctrl;
  logic [ADDR_W-1:0] rdAddr;

  sprLbCtrl #(
    .HCNT_W(HCNT_W), .ADDR_W(ADDR_W), .H_FIRST(H_FIRST), .H_LAST(H_LAST),
    .DRAW_FIRST(DRAW_FIRST), .DRAW_LAST(DRAW_LAST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hCount(hCount), .vBlank(vBlank),
    .stripEn(stripEn), .ctrl(ctrl), .rdAddr(rdAddr)
  );

  sprLbData #(
    .ADDR_W(ADDR_W), .PIX_W(PIX_W), .STRIP_LEN(STRIP_LEN)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .rdAddr(rdAddr),
    .stripX(stripX), .stripPix(stripPix),
    .pixColour(pixColour), .pixValid(pixValid)
  );

  // R6
  valid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixValid |-> ($past(hCount) >= HCNT_W'(READ_FIRST)));

  // R8
  blank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixValid |-> !$past(vBlank));

endmodule

// File: tb/sprLineBuf_tb.sv
module sprLineBuf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // {line[3:0], h[8:0], en, x[7:0], pix[31:0]}
  localparam logic [53:0] VEC [NV] = '{
    {4'd0, 9'd100, 1'b1, 8'd40,  32'h11111111},  // R2 before window
    {4'd0, 9'd144, 1'b1, 8'd100, 32'h99999999},  // R2 first slot
    {4'd0, 9'd150, 1'b1, 8'd10,  32'h87654321},  // R3 pixel order
    {4'd0, 9'd200, 1'b0, 8'd60,  32'h22222222},  // R2 enable low
    {4'd0, 9'd239, 1'b1, 8'd120, 32'hAAAAAAAA},  // R2 last slot
    {4'd0, 9'd240, 1'b1, 8'd80,  32'hBBBBBBBB},  // R2 past window
    {4'd0, 9'd300, 1'b1, 8'd140, 32'hCCCCCCCC},  // R2 during replay
    {4'd2, 9'd160, 1'b1, 8'd252, 32'hFEDCBA98},  // R4 wrap
    {4'd2, 9'd170, 1'b1, 8'd20,  32'h33333333},  // R5 base
    {4'd2, 9'd171, 1'b1, 8'd22,  32'h05050505},  // R5 transparent overlay
    {4'd2, 9'd180, 1'b1, 8'd200, 32'h13579BDF},  // R9 left half
    {4'd2, 9'd181, 1'b1, 8'd208, 32'h2468ACE1},  // R9 right half
    {4'd3, 9'd150, 1'b1, 8'd50,  32'h77777777},  // R8 drawn on blanked line
    {4'd5, 9'd150, 1'b1, 8'd5,   32'h44444444}   // R1 wiped by reset
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  hCount = 9'd128;
  logic        vBlank = 1'b0;
  logic        stripEn = 1'b0;
  logic [7:0]  stripX = '0;
  logic [31:0] stripPix = '0;
  logic [3:0]  pixColour;
  logic        pixValid;

  int          nRun = 0;
  int          nFail = 0;
  logic [3:0]  model [256];
  string       tagOf [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprLineBuf u_dut (
    .clk(clk), .rst_n(rst_n), .hCount(hCount), .vBlank(vBlank),
    .stripEn(stripEn), .stripX(stripX), .stripPix(stripPix),
    .pixColour(pixColour), .pixValid(pixValid)
  );

  function automatic string vecTag(int idx);
    case (idx)
      2:       return "R3";
      7:       return "R4";
      8, 9:    return "R5";
      10, 11:  return "R9";
      12:      return "R8";
      13:      return "R1";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int e = 0; e < 256; e++) begin
      model[e] = '0;
      tagOf[e] = "R7";
    end
  endtask

  // One full line; outputs are checked at each falling edge for the H value
  // seen at the preceding rising edge, then H and the strip inputs advance.
  task automatic runLine(int ln, bit vb, int rstAt);
    vBlank = vb;
    for (int k = 0; k < 384; k++) begin
      int cur;
      int hn;
      @(negedge clk);
      cur = int'(hCount);
      if (cur >= 256 && rst_n) begin
        int a = cur - 256;
        check(pixValid == !vb, vb ? "R8" : "R6", $sformatf("valid H=%0d", cur),
              int'(pixValid), int'(!vb));
        check(pixColour == (vb ? 4'd0 : model[a]), vb ? "R8" : tagOf[a],
              $sformatf("colour entry %0d", a), int'(pixColour), vb ? 0 : int'(model[a]));
        model[a] = '0;
        tagOf[a] = "R7";
      end else begin
        check(!pixValid && pixColour == 4'd0, rst_n ? "R6" : "R1",
              $sformatf("idle H=%0d", cur), int'({pixValid, pixColour}), 0);
      end
      hn = (cur == 511) ? 128 : cur + 1;
      hCount = 9'(hn);
      rst_n = !(rstAt != 0 && hn >= rstAt && hn < rstAt + 3);
      if (!rst_n) clearModel();
      stripEn = 1'b0;
      for (int v = 0; v < NV; v++) begin
        if (int'(VEC[v][53:50]) == ln && int'(VEC[v][49:41]) == hn) begin
          stripEn  = VEC[v][40];
          stripX   = VEC[v][39:32];
          stripPix = VEC[v][31:0];
          for (int i = 0; i < 8; i++) begin
            int e = (int'(VEC[v][39:32]) + i) % 256;
            logic [3:0] p = VEC[v][i*4 +: 4];
            tagOf[e] = vecTag(v);
            if (VEC[v][40] && hn >= 144 && hn <= 239 && p != 4'd0) model[e] = p;
          end
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    clearModel();
    // R1: outputs idle after the first clock under reset
    @(negedge clk);
    check(!pixValid && pixColour == 4'd0, "R1", "reset outputs",
          int'({pixValid, pixColour}), 0);
    runLine(0, 1'b0, 0);    // R2 window edges, R3 placement
    runLine(1, 1'b0, 0);    // R7 buffer replays empty
    runLine(2, 1'b0, 0);    // R4 wrap, R5 transparency, R9 wide sprite
    runLine(3, 1'b1, 0);    // R8 blanked replay still erases
    runLine(4, 1'b0, 0);    // R8 nothing survives the blanked line
    runLine(5, 1'b0, 250);  // R1 reset between drawing and replay
    runLine(6, 1'b0, 0);    // R7 quiet line after reset
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule